// File: doc/BRIEF.md
# Aliased Scalar and Vector Register File

This block is a floating-point and vector register file of 32 entries, each 256 bits wide, that is reached through three views of different width. The scalar view sees the low 64 bits of an entry, the short-vector view sees the low 128 bits, and the long-vector view sees all 256 bits. The views are not separate arrays. They are nested low-order slices of the same storage, so a value written through one view can be read at once through the others.

A single write port carries a view code, an index and 256 bits of data. Only the slice that belongs to the chosen view is updated, and the upper bits of the entry keep their value. Each of the two read ports has its own view code and index. A read returns the selected slice, zero-extended to 256 bits. When a read and a write hit the same index in the same cycle, the read returns the value the entry will hold after the write. This forwarding respects the slice widths of both views.

Top module: `vreg_alias_file`

## Requirements
- R1: While rst_n is low, and after it is released, every entry reads as zero through every view. An asserted reset clears entries that were written before.
- R2: A write with view code 2 (long, 256 bits) replaces the whole entry. From the next cycle on, a long read of that index returns wr_data.
- R3: A read with view code 0 (scalar) returns bits 63:0 of the entry on rd_data bits 63:0 and zeros on bits 255:64.
- R4: A read with view code 1 (short, 128 bits) returns bits 127:0 of the entry on bits 127:0 and zeros on bits 255:128.
- R5: A scalar write (view code 0) replaces bits 63:0 of the entry and leaves bits 255:64 unchanged, as seen through a long read.
- R6: A short write (view code 1) replaces bits 127:0 of the entry and leaves bits 255:128 unchanged.
- R7: A write changes only the entry addressed by wr_idx. All other entries keep their value.
- R8: When a read and a write address the same index in the same cycle, the read returns the value the entry holds after that write, with no delay.
- R9: The same-cycle forwarding of R8 merges the written slice with the old upper bits. For example, a scalar write seen through a long read gives the new bits 63:0 and the old bits 255:64.
- R10: The two read ports choose their view and index independently of each other.
- R11: View code 3 is reserved. A write with this code changes no entry, and a read with this code returns all zeros.
- R12: With wr_en low, no entry changes, and a read of the addressed index returns the stored value whatever wr_data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| wr_en | input | 1 | Write enable |
| wr_view | input | 2 | Write view: 0 scalar, 1 short, 2 long, 3 reserved |
| wr_idx | input | 5 | Write entry index |
| wr_data | input | 256 | Write data; only the slice of the view is used |
| rd_view | input | 2x2 | Per-port read view code, port p at bits [2p+1:2p] |
| rd_idx | input | 2x5 | Per-port read index, port p at bits [5p+4:5p] |
| rd_data | output | 2x256 | Per-port read data, zero-extended slice, port p at bits [256p+255:256p] |

## Verification
Every entry first receives a distinct full-width pattern. The entries are then read through all three views, which separates correct slicing and zero extension from leakage of upper bits, and shows any crosstalk between indices. Scalar and short writes over known full-width contents show whether the upper bits of the entry are kept or lost. Same-cycle pairs of read and write are run with matching and with differing view widths, so a bypass that ignores the slice boundaries gives a wrong value. Reserved-view writes, writes with wr_en low, and a reset in the middle of the run each use data that would be visible if they had any effect.

// File: rtl/vreg_alias_pkg.sv
`timescale 1ns/1ps
package vreg_alias_pkg;
  localparam int unsigned VRF_ENTRIES = 32;
  localparam int unsigned VRF_LOW_W   = 64;
  localparam int unsigned VRF_MID_W   = 128;
  localparam int unsigned VRF_FULL_W  = 256;
  localparam int unsigned VRF_NRD     = 2;

  typedef enum logic [1:0] {
    VW_SCALAR = 2'd0,
    VW_SHORT  = 2'd1,
    VW_LONG   = 2'd2,
    VW_RSVD   = 2'd3
  } view_e;
endpackage

// File: rtl/vreg_view_mask.sv
`timescale 1ns/1ps
// Turns a view code into the bit mask of the slice that view covers.
module vreg_view_mask
  import vreg_alias_pkg::*;
#(
  parameter int unsigned FULL_W = VRF_FULL_W,
  parameter int unsigned MID_W  = VRF_MID_W,
  parameter int unsigned LOW_W  = VRF_LOW_W
) (
  input  logic [1:0]        view,
  output logic [FULL_W-1:0] mask
);
  localparam logic [FULL_W-1:0] MASK_LOW  = {{(FULL_W-LOW_W){1'b0}}, {LOW_W{1'b1}}};
  localparam logic [FULL_W-1:0] MASK_MID  = {{(FULL_W-MID_W){1'b0}}, {MID_W{1'b1}}};
  localparam logic [FULL_W-1:0] MASK_FULL = {FULL_W{1'b1}};

  always_comb begin
    case (view_e'(view))
      VW_SCALAR: mask = MASK_LOW;
      VW_SHORT:  mask = MASK_MID;
      VW_LONG:   mask = MASK_FULL;
      default:   mask = '0;
    endcase
  end
endmodule

// File: rtl/vreg_alias_store.sv
`timescale 1ns/1ps
// Entry storage with a slice-masked write and a clock enable per entry.
module vreg_alias_store
  import vreg_alias_pkg::*;
#(
  parameter int unsigned ENTRIES = VRF_ENTRIES,
  parameter int unsigned FULL_W  = VRF_FULL_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [FULL_W-1:0]              wr_data,
  input  logic [FULL_W-1:0]              wr_mask,
  output logic [ENTRIES-1:0][FULL_W-1:0] ent_q
);
  logic              wr_any;
  logic [FULL_W-1:0] wr_bits;

  assign wr_any  = wr_en && (|wr_mask);
  assign wr_bits = wr_data & wr_mask;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic              ent_ce;
    logic [FULL_W-1:0] ent_d;

    always_comb begin
      ent_ce = wr_any && (wr_idx == IDX_W'(e));
      ent_d  = (ent_q[e] & ~wr_mask) | wr_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[e] <= '0;
      end else if (ent_ce) begin
        ent_q[e] <= ent_d;
      end
    end
  end
endmodule

// File: rtl/vreg_alias_rdport.sv
`timescale 1ns/1ps
// One read port: entry select, same-cycle write merge, slice and zero-extend.
module vreg_alias_rdport
  import vreg_alias_pkg::*;
#(
  parameter int unsigned ENTRIES = VRF_ENTRIES,
  parameter int unsigned FULL_W  = VRF_FULL_W,
  parameter int unsigned MID_W   = VRF_MID_W,
  parameter int unsigned LOW_W   = VRF_LOW_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0][FULL_W-1:0] ent_q,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [FULL_W-1:0]              wr_data,
  input  logic [FULL_W-1:0]              wr_mask,
  input  logic [1:0]                     rd_view,
  input  logic [IDX_W-1:0]               rd_idx,
  output logic [FULL_W-1:0]              rd_data
);
  logic [FULL_W-1:0] rd_mask;
  logic [FULL_W-1:0] ent_sel;
  logic [FULL_W-1:0] ent_fwd;
  logic              fwd_hit;

  vreg_view_mask #(
    .FULL_W (FULL_W),
    .MID_W  (MID_W),
    .LOW_W  (LOW_W)
  ) u_rmask (
    .view (rd_view),
    .mask (rd_mask)
  );

  always_comb begin
    ent_sel = ent_q[rd_idx];
    fwd_hit = wr_en && (wr_idx == rd_idx);
    ent_fwd = fwd_hit ? ((ent_sel & ~wr_mask) | (wr_data & wr_mask)) : ent_sel;
    rd_data = ent_fwd & rd_mask;
  end
endmodule

// File: rtl/vreg_alias_file.sv
`timescale 1ns/1ps
// Top: one masked write port, NRD forwarding read ports over shared entries.
module vreg_alias_file
  import vreg_alias_pkg::*;
#(
  parameter int unsigned ENTRIES = VRF_ENTRIES,
  parameter int unsigned FULL_W  = VRF_FULL_W,
  parameter int unsigned MID_W   = VRF_MID_W,
  parameter int unsigned LOW_W   = VRF_LOW_W,
  parameter int unsigned NRD     = VRF_NRD,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [1:0]                  wr_view,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [FULL_W-1:0]           wr_data,
  input  logic [NRD-1:0][1:0]         rd_view,
  input  logic [NRD-1:0][IDX_W-1:0]   rd_idx,
  output logic [NRD-1:0][FULL_W-1:0]  rd_data
);
  logic [FULL_W-1:0]              wr_mask;
  logic [ENTRIES-1:0][FULL_W-1:0] ent_q;

  vreg_view_mask #(
    .FULL_W (FULL_W),
    .MID_W  (MID_W),
    .LOW_W  (LOW_W)
  ) u_wmask (
    .view (wr_view),
    .mask (wr_mask)
  );

  vreg_alias_store #(
    .ENTRIES (ENTRIES),
    .FULL_W  (FULL_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .wr_mask (wr_mask),
    .ent_q   (ent_q)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    vreg_alias_rdport #(
      .ENTRIES (ENTRIES),
      .FULL_W  (FULL_W),
      .MID_W   (MID_W),
      .LOW_W   (LOW_W)
    ) u_rd (
      .ent_q   (ent_q),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .wr_mask (wr_mask),
      .rd_view (rd_view[p]),
      .rd_idx  (rd_idx[p]),
      .rd_data (rd_data[p])
    );
  end
endmodule

// File: rtl/vreg_alias_file_chk.sv
`timescale 1ns/1ps
module vreg_alias_file_chk #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned FULL_W  = 256,
  parameter int unsigned MID_W   = 128,
  parameter int unsigned LOW_W   = 64,
  parameter int unsigned NRD     = 2,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic [1:0]                  wr_view,
  input logic [IDX_W-1:0]            wr_idx,
  input logic [FULL_W-1:0]           wr_data,
  input logic [NRD-1:0][1:0]         rd_view,
  input logic [NRD-1:0][IDX_W-1:0]   rd_idx,
  input logic [NRD-1:0][FULL_W-1:0]  rd_data
);
  for (genvar p = 0; p < NRD; p++) begin : g_p
    logic same_ix;
    assign same_ix = wr_en && (wr_idx == rd_idx[p]);

    // R3: scalar reads carry nothing above the low slice
    a_r3_scalar_zext: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_view[p] == 2'd0) |-> (rd_data[p][FULL_W-1:LOW_W] == '0));

    // R4: short reads carry nothing above the middle slice
    a_r4_short_zext: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_view[p] == 2'd1) |-> (rd_data[p][FULL_W-1:MID_W] == '0));

    // R11: the reserved view reads as zero
    a_r11_rsvd_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_view[p] == 2'd3) |-> (rd_data[p] == '0));

    // R8: long write seen at once by a long read of the same index
    a_r8_bypass_long: assert property (@(posedge clk) disable iff (!rst_n)
      (same_ix && wr_view == 2'd2 && rd_view[p] == 2'd2) |-> (rd_data[p] == wr_data));

    // R9: scalar write forwarded into the low bits of any non-reserved read
    a_r9_bypass_low: assert property (@(posedge clk) disable iff (!rst_n)
      (same_ix && wr_view == 2'd0 && rd_view[p] != 2'd3)
        |-> (rd_data[p][LOW_W-1:0] == wr_data[LOW_W-1:0]));

    // R12: with no write, an unchanged read address gives unchanged data
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(wr_en) && !wr_en
        && $stable(rd_idx[p]) && $stable(rd_view[p])) |-> $stable(rd_data[p]));
  end
endmodule

bind vreg_alias_file vreg_alias_file_chk #(
  .ENTRIES (ENTRIES),
  .FULL_W  (FULL_W),
  .MID_W   (MID_W),
  .LOW_W   (LOW_W),
  .NRD     (NRD)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_view (wr_view),
  .wr_idx  (wr_idx),
  .wr_data (wr_data),
  .rd_view (rd_view),
  .rd_idx  (rd_idx),
  .rd_data (rd_data)
);

// File: tb/vreg_alias_file_tb.sv
`timescale 1ns/1ps
module vreg_alias_file_tb;
  localparam int NE = 32;
  localparam int FW = 256;
  localparam int NP = 2;
  localparam time HALF = 10ns;

  logic                 clk;
  logic                 rst_n;
  logic                 wr_en;
  logic [1:0]           wr_view;
  logic [4:0]           wr_idx;
  logic [FW-1:0]        wr_data;
  logic [NP-1:0][1:0]   rd_view;
  logic [NP-1:0][4:0]   rd_idx;
  logic [NP-1:0][FW-1:0] rd_data;

  vreg_alias_file u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_view(wr_view),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_view(rd_view),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  typedef struct {
    int          port;
    logic [FW-1:0] exp;
    string       tag;
  } item_t;

  item_t         sb_q[$];
  logic [FW-1:0] model [NE];
  int            n_cmp = 0;
  int            n_bad = 0;
  bit            done  = 0;

  initial clk = 1'b0;
  always #HALF clk = ~clk;

  function automatic logic [FW-1:0] vmask(input logic [1:0] v);
    case (v)
      2'd0:    return {{(FW-64){1'b0}}, {64{1'b1}}};
      2'd1:    return {{(FW-128){1'b0}}, {128{1'b1}}};
      2'd2:    return {FW{1'b1}};
      default: return '0;
    endcase
  endfunction

  function automatic logic [FW-1:0] pat(input int seed);
    logic [FW-1:0] r;
    for (int k = 0; k < FW/32; k++)
      r[k*32 +: 32] = (32'(seed) * 32'h9E37_79B9) ^ (32'(k) * 32'h0101_0101) ^ 32'h5A00_C300;
    return r;
  endfunction

  // Driver: set inputs, push expected results, advance the model.
  task automatic step(input logic we, input logic [1:0] wv, input int wi,
                      input logic [FW-1:0] wd,
                      input logic [1:0] rv0, input int ri0,
                      input logic [1:0] rv1, input int ri1,
                      input string tag0, input string tag1);
    logic [1:0] rvs [2];
    int         ris [2];
    string      tgs [2];
    @(negedge clk);
    wr_en = we; wr_view = wv; wr_idx = 5'(wi); wr_data = wd;
    rd_view[0] = rv0; rd_idx[0] = 5'(ri0);
    rd_view[1] = rv1; rd_idx[1] = 5'(ri1);
    rvs[0] = rv0; rvs[1] = rv1; ris[0] = ri0; ris[1] = ri1;
    tgs[0] = tag0; tgs[1] = tag1;
    #1;
    for (int p = 0; p < NP; p++) begin
      item_t it;
      logic [FW-1:0] m;
      m = model[ris[p]];
      if (we && wi == ris[p])
        m = (m & ~vmask(wv)) | (wd & vmask(wv));
      it.port = p;
      it.exp  = m & vmask(rvs[p]);
      it.tag  = tgs[p];
      sb_q.push_back(it);
    end
    if (we) model[wi] = (model[wi] & ~vmask(wv)) | (wd & vmask(wv));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < NE; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Monitor: compares every pushed item after the driver has settled.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_cmp++;
        if (rd_data[it.port] !== it.exp) begin
          n_bad++;
          $display("FAIL %s port%0d: actual %h expected %h", it.tag, it.port,
                   rd_data[it.port], it.exp);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_view = 2'd0; wr_idx = '0; wr_data = '0;
    rd_view = '0; rd_idx = '0;
    for (int i = 0; i < NE; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state through all views
    for (int i = 0; i < NE; i++)
      step(0, 2'd2, 0, '1, 2'd2, i, 2'(i % 3), NE-1-i, "R1 reset long", "R1 reset view");

    // R2 R7 R10: fill every entry, read a neighbour on the other port
    for (int i = 0; i < NE; i++)
      step(1, 2'd2, i, pat(i), 2'd2, (i+NE-1) % NE, 2'd0, (i+5) % NE,
           "R7 neighbour long", "R10 port1 scalar");
    for (int i = 0; i < NE; i++)
      step(0, 2'd0, 0, '0, 2'd2, i, 2'd2, NE-1-i, "R2 long readback", "R10 port1 long");
    for (int i = 0; i < NE; i++)
      step(0, 2'd0, 0, '0, 2'd0, i, 2'd1, i, "R3 scalar slice", "R4 short slice");

    // R5: scalar write keeps upper bits
    step(1, 2'd0, 5, pat(100), 2'd2, 6, 2'd1, 4, "R7 other entry", "R4 other entry");
    step(0, 2'd0, 0, '0, 2'd2, 5, 2'd1, 5, "R5 scalar write long view", "R5 scalar write short view");
    // R6: short write keeps upper bits
    step(1, 2'd1, 6, pat(200), 2'd0, 7, 2'd0, 5, "R7 other entry", "R3 after scalar write");
    step(0, 2'd0, 0, '0, 2'd2, 6, 2'd0, 6, "R6 short write long view", "R6 short write scalar view");

    // R8 R9: same-cycle forwarding
    step(1, 2'd2, 9, pat(300), 2'd2, 9, 2'd0, 9, "R8 bypass long", "R8 bypass scalar");
    step(1, 2'd0, 10, pat(301), 2'd2, 10, 2'd1, 10, "R9 scalar into long", "R9 scalar into short");
    step(1, 2'd1, 11, pat(302), 2'd0, 11, 2'd2, 11, "R9 short into scalar", "R9 short into long");
    step(1, 2'd2, 12, pat(303), 2'd2, 13, 2'd1, 12, "R8 no hit other index", "R8 long into short");
    step(0, 2'd0, 0, '0, 2'd2, 10, 2'd2, 11, "R9 stored after scalar", "R9 stored after short");

    // R11: reserved view
    step(1, 2'd3, 14, '1, 2'd2, 14, 2'd3, 14, "R11 rsvd write bypass", "R11 rsvd read");
    step(0, 2'd0, 0, '0, 2'd2, 14, 2'd3, 3, "R11 rsvd write ignored", "R11 rsvd read");

    // R12: wr_en low
    step(0, 2'd2, 15, '1, 2'd2, 15, 2'd0, 15, "R12 disabled same cycle", "R12 disabled scalar");
    step(0, 2'd1, 15, '0, 2'd2, 15, 2'd1, 15, "R12 disabled next cycle", "R12 disabled short");

    // R1: reset clears written contents
    do_reset();
    for (int i = 0; i < NE; i++)
      step(0, 2'd0, 0, '0, 2'd2, i, 2'd1, NE-1-i, "R1 cleared long", "R1 cleared short");

    step(0, 2'd0, 0, '0, 2'd0, 0, 2'd0, 0, "R1 final", "R1 final");
    @(negedge clk);
    #5;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule